// File: doc/BRIEF.md
# Buffered-Load Cascadable Program Counter

This block is a 16-bit program counter assembled from identical 8-bit slices. Each slice holds a staging register, a binary counter and a drive path onto one shared bidirectional data bus. A jump target is first captured from the bus into the staging registers. A separate transfer command then moves the staged value into the counters. No path exists from the bus straight into a counter.

During normal execution the count enable steps the counter by one on each clock. Each slice passes an active-low carry to the slice above it, and that carry serves as the upper slice's count enable, so the two slices step as one 16-bit value. When the output enable is high, the counter value is placed on the bus. Otherwise the bus is released for other drivers. All state runs on one system clock. The transfer command is a synchronous input, so a jump takes one edge for the capture and a later edge for the transfer.

Top module: `bufload_pc`

## Requirements
- R1: While `rst_n` is low, the counter and the staging register are both 0x0000 and `carry_n` is high.
- R2: On a rising edge with `stage_en_n` low, the staging register takes the 16-bit bus value. With `stage_en_n` high, the staging register keeps its value. Counting and clearing never change the staging register.
- R3: On a rising edge with `xfer_n` low and `clr_n` high, the counter takes the staging register contents as they stood before that edge. A capture in the same edge does not reach the counter until a later transfer.
- R4: On a rising edge with `count_en` high and both `clr_n` and `xfer_n` high, the counter increases by one modulo 65536. With `count_en` low, the counter holds.
- R5: A step from 0x12FF reaches 0x1300 in a single edge: the low slice wraps and the high slice steps once.
- R6: `carry_n` is low exactly when the counter is 0xFFFF, `count_en` is high, and `clr_n` and `xfer_n` are both high. The next edge then yields 0x0000.
- R7: On a rising edge with `clr_n` low, the counter becomes 0x0000. This takes priority over transfer and over counting.
- R8: A transfer takes priority over counting when both are requested on the same edge.
- R9: With `oe` high, `pc_bus` carries the counter value. With `oe` low, the block does not drive `pc_bus`, and a value driven from outside appears on the bus unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; both the staging registers and the counters run on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| stage_en_n | input | 1 | Active-low capture of the bus into the staging register |
| xfer_n | input | 1 | Active-low transfer of the staging register into the counter |
| count_en | input | 1 | Active-high increment request for the low slice |
| clr_n | input | 1 | Active-low synchronous counter clear |
| oe | input | 1 | High drives the counter onto the bus; low releases the bus |
| pc_bus | inout | 16 | Shared data bus |
| carry_n | output | 1 | Active-low carry out of the top slice |

## Verification
The bench stages a target of 0x12FE and steps the counter across the slice boundary. A broken carry chain would either leave the high byte at 0x12 or step it too early. It issues a capture and a transfer on the same edge. A counter fed from the bus instead of from the staging register would pick up the new value one edge early. It checks the priority between clear, transfer and increment. It also checks that the staging register survives a clear, that the carry appears only at 0xFFFF while counting is active, and that the bus shows an external value untouched while `oe` is low.

// File: rtl/pc_pkg.sv
package pc_pkg;

  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_CLEAR = 2'd1,
    OP_XFER  = 2'd2,
    OP_STEP  = 2'd3
  } cnt_op_e;

  // Counter-side priority: clear, then transfer, then step.
  function automatic cnt_op_e decode_op(input logic clr_n,
                                        input logic xfer_n,
                                        input logic step_en_n);
    cnt_op_e op;
    if (!clr_n)          op = OP_CLEAR;
    else if (!xfer_n)    op = OP_XFER;
    else if (!step_en_n) op = OP_STEP;
    else                 op = OP_HOLD;
    return op;
  endfunction

endpackage

// File: rtl/pc_stage_reg.sv
module pc_stage_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         stage_en_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] q_nxt;

  always_comb begin
    q_nxt = q;
    if (!stage_en_n) q_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end

endmodule

// File: rtl/pc_count_reg.sv
module pc_count_reg
  import pc_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_n,
  input  logic         xfer_n,
  input  logic         step_en_n,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] cnt,
  output logic         ripple_n
);

  cnt_op_e      op;
  logic [W-1:0] cnt_nxt;

  assign op = decode_op(clr_n, xfer_n, step_en_n);

  always_comb begin
    unique case (op)
      OP_CLEAR: cnt_nxt = '0;
      OP_XFER:  cnt_nxt = load_val;
      OP_STEP:  cnt_nxt = cnt + W'(1);
      default:  cnt_nxt = cnt;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_nxt;
  end

  // The carry is asserted only when this slice is about to wrap.
  assign ripple_n = !((op == OP_STEP) && (&cnt));

endmodule

// File: rtl/pc_slice.sv
module pc_slice #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         stage_en_n,
  input  logic         xfer_n,
  input  logic         clr_n,
  input  logic         step_en_n,
  input  logic [W-1:0] bus_in,
  output logic [W-1:0] cnt,
  output logic [W-1:0] staged,
  output logic         ripple_n
);

  pc_stage_reg #(.W(W)) u_stage (
    .clk        (clk),
    .rst_n      (rst_n),
    .stage_en_n (stage_en_n),
    .d          (bus_in),
    .q          (staged)
  );

  pc_count_reg #(.W(W)) u_count (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_n     (clr_n),
    .xfer_n    (xfer_n),
    .step_en_n (step_en_n),
    .load_val  (staged),
    .cnt       (cnt),
    .ripple_n  (ripple_n)
  );

endmodule

// File: rtl/bufload_pc.sv
module bufload_pc #(
  parameter int SLICE_W    = 8,
  parameter int NUM_SLICES = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          stage_en_n,
  input  logic                          xfer_n,
  input  logic                          count_en,
  input  logic                          clr_n,
  input  logic                          oe,
  inout  wire  [SLICE_W*NUM_SLICES-1:0] pc_bus,
  output logic                          carry_n
);

  localparam int PC_W = SLICE_W * NUM_SLICES;

  logic [PC_W-1:0]     bus_in;
  logic [PC_W-1:0]     pc_q;
  logic [PC_W-1:0]     hold_q;
  logic [NUM_SLICES:0] en_chain_n;

  assign bus_in        = pc_bus;
  assign en_chain_n[0] = !count_en;

  for (genvar gi = 0; gi < NUM_SLICES; gi++) begin : g_slice
    pc_slice #(.W(SLICE_W)) u_slice (
      .clk        (clk),
      .rst_n      (rst_n),
      .stage_en_n (stage_en_n),
      .xfer_n     (xfer_n),
      .clr_n      (clr_n),
      .step_en_n  (en_chain_n[gi]),
      .bus_in     (bus_in[gi*SLICE_W +: SLICE_W]),
      .cnt        (pc_q[gi*SLICE_W +: SLICE_W]),
      .staged     (hold_q[gi*SLICE_W +: SLICE_W]),
      .ripple_n   (en_chain_n[gi+1])
    );
  end

  assign carry_n = en_chain_n[NUM_SLICES];
  assign pc_bus  = oe ? pc_q : {PC_W{1'bz}};

endmodule

// File: rtl/bufload_pc_checker.sv
module bufload_pc_checker #(
  parameter int PC_W = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            stage_en_n,
  input logic            xfer_n,
  input logic            count_en,
  input logic            clr_n,
  input logic            oe,
  input logic [PC_W-1:0] bus_in,
  input logic [PC_W-1:0] pc_q,
  input logic [PC_W-1:0] hold_q,
  input logic            carry_n
);

  AST_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    !stage_en_n |=> hold_q == $past(bus_in)); // R2

  AST_HOLD_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    stage_en_n |=> $stable(hold_q)); // R2

  AST_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && !xfer_n) |=> pc_q == $past(hold_q)); // R3

  AST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (count_en && clr_n && xfer_n) |=> pc_q == $past(pc_q) + PC_W'(1)); // R4

  AST_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!count_en && clr_n && xfer_n) |=> $stable(pc_q)); // R4

  AST_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    !carry_n |-> ((&pc_q) && count_en && clr_n && xfer_n)); // R6

  AST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |=> pc_q == '0); // R7

  AST_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    oe |-> bus_in == pc_q); // R9

endmodule

bind bufload_pc bufload_pc_checker #(.PC_W(SLICE_W * NUM_SLICES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .stage_en_n (stage_en_n),
  .xfer_n     (xfer_n),
  .count_en   (count_en),
  .clr_n      (clr_n),
  .oe         (oe),
  .bus_in     (bus_in),
  .pc_q       (pc_q),
  .hold_q     (hold_q),
  .carry_n    (carry_n)
);

// File: tb/bufload_pc_test.sv
`timescale 1ns/100ps
module bufload_pc_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        stage_en_n = 1'b1;
  logic        xfer_n = 1'b1;
  logic        count_en = 1'b0;
  logic        clr_n = 1'b1;
  logic        oe = 1'b0;
  logic        tb_drive = 1'b1;
  logic [15:0] tb_val = 16'h0000;
  wire  [15:0] pc_bus;
  logic        carry_n;

  int tests = 0;
  int fails = 0;
  int ref_pc = 0;
  int ref_hold = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  assign pc_bus = tb_drive ? tb_val : 16'hzzzz;

  bufload_pc uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .stage_en_n (stage_en_n),
    .xfer_n     (xfer_n),
    .count_en   (count_en),
    .clr_n      (clr_n),
    .oe         (oe),
    .pc_bus     (pc_bus),
    .carry_n    (carry_n)
  );

  task automatic check(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // One clock: drive at negedge, check combinational outputs, then update model at posedge.
  task automatic cyc(input string tag, input bit s_n, input bit x_n, input bit ce,
                     input bit c_n, input bit o, input logic [15:0] val);
    int bus_v;
    @(negedge clk);
    stage_en_n = s_n; xfer_n = x_n; count_en = ce; clr_n = c_n; oe = o;
    tb_drive = !o; tb_val = val;
    #1;
    bus_v = o ? ref_pc : int'(val);
    check({tag, " bus"}, int'(pc_bus), bus_v);
    check({tag, " carry R6"}, int'(carry_n),
          (ref_pc == 16'hFFFF && ce && c_n && x_n) ? 0 : 1);
    @(posedge clk);
    begin
      int new_pc;
      if (!c_n)      new_pc = 0;
      else if (!x_n) new_pc = ref_hold;
      else if (ce)   new_pc = (ref_pc + 1) & 16'hFFFF;
      else           new_pc = ref_pc;
      if (!s_n) ref_hold = bus_v;
      ref_pc = new_pc;
    end
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    oe = 1'b1; tb_drive = 1'b0;
    #1;
    check("R1 reset counter", int'(pc_bus), 0);
    check("R1 reset carry", int'(carry_n), 1);
    rst_n = 1'b1;

    cyc("R1 idle", 1, 1, 0, 1, 1, 16'h0);
    cyc("R2 capture 12FE", 0, 1, 0, 1, 0, 16'h12FE);
    cyc("R3 counter untouched by capture", 1, 1, 0, 1, 1, 16'h0);
    cyc("R3 transfer", 1, 0, 0, 1, 1, 16'h0);
    cyc("R3 after transfer", 1, 1, 0, 1, 1, 16'h0);
    cyc("R4 step to 12FF", 1, 1, 1, 1, 1, 16'h0);
    cyc("R5 step across slice", 1, 1, 1, 1, 1, 16'h0);
    cyc("R5 read 1300", 1, 1, 0, 1, 1, 16'h0);
    cyc("R4 hold", 1, 1, 0, 1, 1, 16'h0);
    cyc("R9 float external", 1, 1, 0, 1, 0, 16'hA5C3);
    cyc("R9 drive again", 1, 1, 0, 1, 1, 16'h0);
    cyc("R3 capture and transfer same edge", 0, 0, 0, 1, 0, 16'h4455);
    cyc("R3 old target loaded", 1, 1, 0, 1, 1, 16'h0);
    cyc("R3 new target transfer", 1, 0, 0, 1, 1, 16'h0);
    cyc("R8 transfer over step", 1, 0, 1, 1, 1, 16'h0);
    cyc("R7 clear over transfer", 1, 0, 1, 0, 1, 16'h0);
    cyc("R7 cleared", 1, 1, 0, 1, 1, 16'h0);
    cyc("R2 staging survives clear", 1, 0, 0, 1, 1, 16'h0);
    cyc("R2 capture FFFF", 0, 1, 0, 1, 0, 16'hFFFF);
    cyc("R6 load FFFF", 1, 0, 0, 1, 1, 16'h0);
    cyc("R6 no carry when idle", 1, 1, 0, 1, 1, 16'h0);
    cyc("R6 wrap with carry", 1, 1, 1, 1, 1, 16'h0);
    cyc("R6 read 0000", 1, 1, 1, 1, 1, 16'h0);
    for (int k = 0; k < 300; k++) cyc("R4 run", 1, 1, 1, 1, 1, 16'h0);
    cyc("R2 staging kept after counting", 1, 0, 0, 1, 1, 16'h0);
    cyc("R2 final", 1, 1, 0, 1, 1, 16'h0);

    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 async reset", int'(pc_bus), 0);
    done = 1;
    summary();
  end

endmodule